// File: doc/BRIEF.md
# Instruction Fetch Queue with Decode-Slot Bypass

This block sits between the instruction fetch port and a single-issue execute stage. It keeps up to three fetched instruction words, each with its address. One of them sits in a dedicated decode slot, and only that slot is shown to the execute stage. The other two wait in a small prefetch area. When the execute stage stalls, new fetches pile up in the prefetch area in arrival order, so no word is lost. When the prefetch area is empty and the decode slot is free or being drained, an arriving word skips the prefetch area and lands directly in the decode slot. That word is offered to execute on the very next cycle.

Both edges use a valid/ready handshake, and a word moves on a rising clock edge where valid and ready are both high. A flush input, used on a branch redirect, empties all three slots in one cycle. A word offered by fetch in that same cycle is thrown away.

Top module: `insn_fetch_queue`

## Requirements
- R1: The queue never holds more than three words. While the decode slot and both prefetch slots are occupied and `deq_ready` is low, `fetch_ready` is low.
- R2: A word accepted while the queue is empty is presented on `deq_valid`/`deq_insn`/`deq_addr` in the cycle right after the accepting edge.
- R3: While `deq_valid` is high and `deq_ready` is low (no flush), the presented word and address stay unchanged and `deq_valid` stays high on the next cycle.
- R4: Words leave on the decode side in exactly the order they were accepted on the fetch side, with the oldest first. A newly arriving word never overtakes one that is waiting in the prefetch slots.
- R5: `fetch_ready` is low only in the condition of R1. In particular, a full queue whose decode word is consumed in the same cycle still accepts a new fetch.
- R6: A cycle with `redirect_flush` high leaves the queue empty on the next cycle, with `deq_valid` low. A fetch offered in the flush cycle is discarded and never appears at the output.
- R7: After a cycle with `rst_n` low, `deq_valid` is low and `fetch_ready` is high.
- R8: A word is taken only on an edge where `fetch_valid` and `fetch_ready` are both high. The presented word advances only on an edge where `deq_valid` and `deq_ready` are both high. `deq_valid` is high exactly when at least one accepted, un-flushed word has not yet been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| redirect_flush | input | 1 | Empties every slot; discards a fetch offered in the same cycle |
| fetch_valid | input | 1 | Fetch side offers a word |
| fetch_ready | output | 1 | Queue can take the offered word |
| fetch_insn | input | 32 | Offered instruction word |
| fetch_addr | input | 32 | Address of the offered word |
| deq_valid | output | 1 | Decode slot holds a word for execute |
| deq_ready | input | 1 | Execute stage takes the word (low = stall) |
| deq_insn | output | 32 | Instruction word in the decode slot |
| deq_addr | output | 32 | Address of the word in the decode slot |

## Verification
The bench targets four situations:

- **Empty-queue bypass.** A design that always went through the prefetch slots would show the word one cycle late.
- **Fetch on a full queue while execute is draining.** A design that tied ready only to fullness would throttle fetch for no reason. A design that wrote at the wrong prefetch index would duplicate a word or drop one.
- **Arrival while a word is already waiting in prefetch.** A careless bypass would let the new word overtake, and execute would run instructions out of order.
- **Flush with a fetch offered in the same cycle.** A design that let that word in would present a stale instruction after the redirect.

Random stall and flush traffic is then compared word by word against a reference queue.

// File: rtl/ifq_pkg.sv
// Package: ifq_pkg
// Shared widths and the entry type carried through the fetch queue.
// Assumes 32-bit instruction words and 32-bit byte addresses.
package ifq_pkg;
    localparam int INSN_W = 32;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
    } ifq_entry_t;
endpackage

// File: rtl/ifq_slot.sv
// Module: ifq_slot
// One storage register for a queue entry. It takes `d` when `load` is high.
// It assumes that validity is tracked by the control logic, not here.
module ifq_slot
    import ifq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  ifq_entry_t d,
    output ifq_entry_t q
);
    // Capture a new entry on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/ifq_prefetch_bank.sv
// Module: ifq_prefetch_bank
// An ordered prefetch store with PF_DEPTH slots. Slot 0 always holds the oldest word.
// On `shift`, every slot moves one place toward slot 0.
// On `wr_en`, the incoming entry goes to slot `wr_idx`, which already takes that shift into account.
// It assumes the controller never writes past the occupied count.
module ifq_prefetch_bank
    import ifq_pkg::*;
#(
    parameter int PF_DEPTH = 2,
    localparam int IDX_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ifq_entry_t       wr_data,
    output ifq_entry_t       head
);
    ifq_entry_t slot_q [PF_DEPTH];

    for (genvar i = 0; i < PF_DEPTH; i++) begin : g_slot
        ifq_entry_t slot_d;
        logic       slot_ld;
        logic       hit;

        // A slot is written when the new entry targets it, or when the bank shifts.
        always_comb begin
            hit     = wr_en && (wr_idx == IDX_W'(i));
            slot_ld = hit || shift;
            if (hit)
                slot_d = wr_data;
            else if (i + 1 < PF_DEPTH)
                slot_d = slot_q[(i + 1 < PF_DEPTH) ? i + 1 : i];
            else
                slot_d = slot_q[i];
        end

        ifq_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_ld),
            .d     (slot_d),
            .q     (slot_q[i])
        );
    end

    assign head = slot_q[0];
endmodule

// File: rtl/ifq_ctrl.sv
// Module: ifq_ctrl
// Occupancy and steering control for the fetch queue.
// It tracks whether the decode slot is valid and how many prefetch slots are filled.
// Each cycle it decides whether to bypass, refill the decode slot from prefetch, or append to prefetch.
// It assumes the prefetch bank keeps program order, with slot 0 oldest.
module ifq_ctrl #(
    parameter int PF_DEPTH = 2,
    localparam int CNT_W = $clog2(PF_DEPTH + 1),
    localparam int IDX_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             dec_valid,
    output logic             dec_load,
    output logic             dec_from_pf,
    output logic             pf_shift,
    output logic             pf_wr,
    output logic [IDX_W-1:0] pf_wr_idx
);
    logic [CNT_W-1:0] pf_cnt;
    logic [CNT_W-1:0] pf_cnt_n;
    logic [CNT_W-1:0] wr_pos;
    logic             dec_valid_n;
    logic             out_fire;
    logic             in_fire;
    logic             dec_free;
    logic             pf_empty;
    logic             pf_full;
    logic             bypass;

    // Derive the handshakes and the steering decision for this cycle.
    always_comb begin
        pf_empty    = (pf_cnt == '0);
        pf_full     = (pf_cnt == CNT_W'(PF_DEPTH));
        in_ready    = !(dec_valid && pf_full) || out_ready;
        out_fire    = dec_valid && out_ready;
        in_fire     = in_valid && in_ready && !flush;
        dec_free    = !dec_valid || out_fire;
        pf_shift    = dec_free && !pf_empty && !flush;
        bypass      = dec_free && pf_empty && in_fire;
        pf_wr       = in_fire && !bypass;
        wr_pos      = pf_cnt - CNT_W'(pf_shift);
        pf_wr_idx   = IDX_W'(wr_pos);
        dec_load    = pf_shift || bypass;
        dec_from_pf = pf_shift;
    end

    // Next occupancy of the prefetch area and the decode slot.
    always_comb begin
        if (flush) begin
            pf_cnt_n    = '0;
            dec_valid_n = 1'b0;
        end else begin
            pf_cnt_n    = pf_cnt + CNT_W'(pf_wr) - CNT_W'(pf_shift);
            if (dec_load)
                dec_valid_n = 1'b1;
            else if (out_fire)
                dec_valid_n = 1'b0;
            else
                dec_valid_n = dec_valid;
        end
    end

    // Register the occupancy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_cnt    <= '0;
            dec_valid <= 1'b0;
        end else begin
            pf_cnt    <= pf_cnt_n;
            dec_valid <= dec_valid_n;
        end
    end
endmodule

// File: rtl/insn_fetch_queue.sv
// Module: insn_fetch_queue
// Three-entry instruction queue between fetch and a single-issue execute stage.
// It has PF_DEPTH prefetch slots plus one decode slot, and only the decode slot is presented downstream.
// When the prefetch slots are empty, an arriving word bypasses into the decode slot.
// It assumes the fetch side holds its word stable until accepted, and that a flush overrides any fetch in the same cycle.
module insn_fetch_queue
    import ifq_pkg::*;
#(
    parameter int PF_DEPTH = 2,
    localparam int IDX_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_flush,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [INSN_W-1:0] fetch_insn,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              deq_valid,
    input  logic              deq_ready,
    output logic [INSN_W-1:0] deq_insn,
    output logic [ADDR_W-1:0] deq_addr
);
    ifq_entry_t       in_entry;
    ifq_entry_t       pf_head;
    ifq_entry_t       dec_d;
    ifq_entry_t       dec_q;
    logic             dec_load;
    logic             dec_from_pf;
    logic             pf_shift;
    logic             pf_wr;
    logic [IDX_W-1:0] pf_wr_idx;

    // Pack the fetch-side fields into an entry.
    always_comb begin
        in_entry.insn = fetch_insn;
        in_entry.addr = fetch_addr;
    end

    ifq_ctrl #(.PF_DEPTH(PF_DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (redirect_flush),
        .in_valid    (fetch_valid),
        .out_ready   (deq_ready),
        .in_ready    (fetch_ready),
        .dec_valid   (deq_valid),
        .dec_load    (dec_load),
        .dec_from_pf (dec_from_pf),
        .pf_shift    (pf_shift),
        .pf_wr       (pf_wr),
        .pf_wr_idx   (pf_wr_idx)
    );

    ifq_prefetch_bank #(.PF_DEPTH(PF_DEPTH)) u_pf (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (pf_shift),
        .wr_en   (pf_wr),
        .wr_idx  (pf_wr_idx),
        .wr_data (in_entry),
        .head    (pf_head)
    );

    // Choose the decode slot source: the oldest prefetch word, or the bypassing fetch.
    always_comb dec_d = dec_from_pf ? pf_head : in_entry;

    ifq_slot u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dec_load),
        .d     (dec_d),
        .q     (dec_q)
    );

    assign deq_insn = dec_q.insn;
    assign deq_addr = dec_q.addr;
endmodule

// File: rtl/ifq_checker.sv
// Module: ifq_checker
// Port-level properties of the fetch queue. It keeps its own occupancy count,
// built from the handshakes alone, and checks the outputs against it.
module ifq_checker
    import ifq_pkg::*;
#(
    parameter int PF_DEPTH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_flush,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic [INSN_W-1:0] fetch_insn,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              deq_valid,
    input logic              deq_ready,
    input logic [INSN_W-1:0] deq_insn,
    input logic [ADDR_W-1:0] deq_addr
);
    localparam int CAP = PF_DEPTH + 1;
    int  occ;
    logic acc;
    logic take;

    assign acc  = fetch_valid && fetch_ready && !redirect_flush;
    assign take = deq_valid && deq_ready;

    // Track occupancy from the port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= 0;
        else if (redirect_flush)
            occ <= 0;
        else
            occ <= occ + (acc ? 1 : 0) - (take ? 1 : 0);
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CAP);
    assert_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CAP && !deq_ready) |-> !fetch_ready);
    assert_bypass_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && occ == 0) |=> (deq_valid && deq_insn == $past(fetch_insn)
                               && deq_addr == $past(fetch_addr)));
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready && !redirect_flush) |=>
            (deq_valid && $stable(deq_insn) && $stable(deq_addr)));
    assert_ready_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < CAP || deq_ready) |-> fetch_ready);
    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_flush |=> !deq_valid);
    assert_reset_idle_R7: assert property (@(posedge clk)
        !rst_n |=> (!deq_valid && fetch_ready));
    assert_valid_occ_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid == (occ != 0));
endmodule

bind insn_fetch_queue ifq_checker #(.PF_DEPTH(PF_DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_flush (redirect_flush),
    .fetch_valid    (fetch_valid),
    .fetch_ready    (fetch_ready),
    .fetch_insn     (fetch_insn),
    .fetch_addr     (fetch_addr),
    .deq_valid      (deq_valid),
    .deq_ready      (deq_ready),
    .deq_insn       (deq_insn),
    .deq_addr       (deq_addr)
);

// File: tb/insn_fetch_queue_tb.sv
// Directed bench for insn_fetch_queue: one task per scenario, checked against a reference queue.
module insn_fetch_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_insn = '0;
    logic [31:0] fetch_addr = '0;
    logic        deq_valid;
    logic        deq_ready = 1'b0;
    logic [31:0] deq_insn;
    logic [31:0] deq_addr;

    int total = 0;
    int bad = 0;
    int next_id = 1;
    logic [31:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_fetch_queue u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .redirect_flush (redirect_flush),
        .fetch_valid    (fetch_valid),
        .fetch_ready    (fetch_ready),
        .fetch_insn     (fetch_insn),
        .fetch_addr     (fetch_addr),
        .deq_valid      (deq_valid),
        .deq_ready      (deq_ready),
        .deq_insn       (deq_insn),
        .deq_addr       (deq_addr)
    );

    function automatic logic [31:0] insn_of(int id);
        return 32'hA500_0000 + 32'(id);
    endfunction
    function automatic logic [31:0] addr_of(logic [31:0] insn);
        return {insn[29:0], 2'b00} ^ 32'h0001_0000;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check the outputs, update the reference, then let the edge pass.
    task automatic step(bit iv, bit ordy, bit fl, string req);
        bit ofire;
        bit ifire;
        @(negedge clk);
        fetch_valid    = iv;
        fetch_insn     = insn_of(next_id);
        fetch_addr     = addr_of(insn_of(next_id));
        deq_ready      = ordy;
        redirect_flush = fl;
        #1;
        chk(req, "deq_valid", 32'(deq_valid), 32'(mq.size() != 0));
        chk(req, "fetch_ready", 32'(fetch_ready), 32'(!(mq.size() == CAP && !ordy)));
        if (deq_valid && mq.size() != 0) begin
            chk(req, "deq_insn", deq_insn, mq[0]);
            chk(req, "deq_addr", deq_addr, addr_of(mq[0]));
        end
        ofire = deq_valid && ordy;
        ifire = iv && fetch_ready && !fl;
        if (ofire && mq.size() != 0) void'(mq.pop_front());
        if (fl) begin
            mq.delete();
            next_id++;
        end else if (ifire) begin
            mq.push_back(insn_of(next_id));
            next_id++;
        end
        @(posedge clk);
    endtask

    task automatic drain(string req);
        for (int i = 0; i < 6; i++) step(0, 1, 0, req);
    endtask

    task automatic test_reset();
        step(0, 0, 0, "R7");
    endtask

    task automatic test_bypass();
        step(1, 0, 0, "R2");
        step(0, 0, 0, "R2");
        step(0, 1, 0, "R2");
        step(0, 0, 0, "R2");
    endtask

    task automatic test_stall_fill();
        for (int i = 0; i < 5; i++) step(1, 0, 0, (i < 3) ? "R3" : "R1");
        step(0, 0, 0, "R3");
    endtask

    task automatic test_full_swap();
        step(1, 1, 0, "R5");
        step(1, 0, 0, "R5");
        step(1, 1, 0, "R5");
        step(0, 0, 0, "R5");
        drain("R4");
    endtask

    task automatic test_no_overtake();
        step(1, 0, 0, "R4");
        step(1, 0, 0, "R4");
        step(1, 1, 0, "R4");
        step(1, 1, 0, "R4");
        drain("R4");
    endtask

    task automatic test_flush();
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R6");
        step(1, 0, 1, "R6");
        step(0, 0, 0, "R6");
        step(1, 0, 0, "R6");
        step(0, 1, 0, "R6");
        step(1, 1, 1, "R6");
        step(0, 1, 0, "R6");
    endtask

    task automatic test_random();
        for (int i = 0; i < 600; i++)
            step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 40) == 0, "R8");
        drain("R8");
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_bypass();
        test_stall_fill();
        test_full_swap();
        test_no_overtake();
        test_flush();
        test_random();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end
endmodule